// File: doc/BRIEF.md
# Gate-Shading Scan Level-Shift Controller

This block is the digital control core of a seven-lane scan driver for a thin-film panel: one start-pulse lane and six clock lanes. Every lane normally copies its logic input to a push-pull output stage, expressed as separate drive-high, drive-low and high-impedance commands. Clock lanes also have a discharge-switch command. All inputs pass through a multi-stage synchronizer before use.

A falling edge on any clock lane opens a gate-shading window, but only while the timing ramp is idle and has decayed below a programmable floor. An internal counter stands in for the RC ramp. While the window is open, a clock lane whose input is low stops driving. It floats and closes its discharge switch onto one of two shared rails, one for the even-indexed lanes and one for the odd-indexed lanes. The window closes when the ramp reaches a programmable top count. A discharge phase of programmable length follows. The ramp then keeps halving until it falls below the floor, and only then can the next window open.

Top module: `scan_shade_ctrl`

## Requirements
- R1: While `chip_en` is low every lane output is high-impedance (`*_hiz`=1, drive-high and drive-low 0), no discharge switch or rail is on and `shade_busy` is 0. Reset clears the synchronizers, so the lanes read as low and no window is open.
- R2: With `chip_en` high and no window open, clock lane i drives high when its synchronized input is 1 and low when it is 0. Exactly one of hi/lo/hiz is set. The output reflects the input value captured two rising edges earlier.
- R3: An input pulse that begins and ends between two rising clock edges has no effect on any output.
- R4: With `chip_en` and `shade_en` high, the ramp idle and the ramp count below `ramp_floor`, a 1-to-0 change on any `ck_in` bit sets `shade_busy` after the third rising edge that follows the change.
- R5: While `shade_busy` is 1, a clock lane whose synchronized input is 0 has `ck_hiz`=1 and `ck_dis`=1, and a lane whose input is 1 drives high.
- R6: Discharging lanes at indices 0, 2 and 4 turn on `rail_odd_on`. Lanes at indices 1, 3 and 5 turn on `rail_even_on`.
- R7: A window lasts `ramp_top` − r cycles, with a minimum of one, where r is the ramp count when the window opens. The ramp counts up by one each cycle while the window is open. After a long idle, r is 0.
- R8: A closed window is followed by a discharge phase of max(`dump_len`,1) cycles. During that phase and while idle, the ramp halves every cycle. Falling edges during a window or a discharge phase are ignored. A new window needs the idle state and a ramp below `ramp_floor`.
- R9: With `shade_en` low, all lanes follow their inputs, any open window is dropped and the ramp is cleared.
- R10: The start-pulse lane is never shaded. With `chip_en` high it always follows `st_in` with the same latency as R2.
- R11: A `ramp_floor` of 0 prevents any window from opening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Output enable; low floats every lane |
| shade_en | input | 1 | Gate-shading enable |
| st_in | input | 1 | Start-pulse logic input |
| ck_in | input | NUM_CK | Clock-lane logic inputs |
| ramp_top | input | CNT_W | Ramp count that closes a window |
| ramp_floor | input | CNT_W | Ramp must be below this to arm |
| dump_len | input | CNT_W | Discharge phase length in cycles |
| st_hi | output | 1 | Start lane drive high |
| st_lo | output | 1 | Start lane drive low |
| st_hiz | output | 1 | Start lane high-impedance |
| ck_hi | output | NUM_CK | Clock lane drive high |
| ck_lo | output | NUM_CK | Clock lane drive low |
| ck_hiz | output | NUM_CK | Clock lane high-impedance |
| ck_dis | output | NUM_CK | Clock lane discharge switch closed |
| rail_odd_on | output | 1 | Discharge rail for lanes 0, 2, 4 in use |
| rail_even_on | output | 1 | Discharge rail for lanes 1, 3, 5 in use |
| shade_busy | output | 1 | Shading window open |

## Verification
The assertions watch the properties that hold on every cycle: each lane sits in exactly one drive state, a discharge happens only while floating, the rails light only inside a window, a disabled block floats everything, a window opens only from an armed ramp, and the phase never skips discharge or jumps from discharge back to ramping. They cannot show window length, the three-edge start latency, the halving decay that gates re-arming, or that sub-cycle glitches are ignored. Those come from the bench scenarios, which run a requirement-derived countdown model against the outputs under random edges and several top, floor and discharge settings, and add directed cases for each boundary.

// File: rtl/scan_shade_pkg.sv
`timescale 1ns/1ps
package scan_shade_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RISE = 2'd1,
    PH_DUMP = 2'd2
  } shade_phase_e;

  // Lanes with an even index share the "odd" rail (channels 1, 3, 5).
  function automatic logic odd_rail_lane(input int unsigned idx);
    return (idx % 2) == 0;
  endfunction

endpackage

// File: rtl/scan_edge_sync.sv
`timescale 1ns/1ps
module scan_edge_sync #(
  parameter int unsigned LANES      = 7,
  parameter int unsigned EDGE_LANES = 6,
  parameter int unsigned STAGES     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      raw_i,
  output logic [LANES-1:0]      lvl_o,
  output logic [EDGE_LANES-1:0] fall_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][LANES-1:0] pipe_q;
  logic [EDGE_LANES-1:0]        prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      prev_q <= '0;
    end else begin
      pipe_q[0] <= raw_i;
      for (int s = 1; s < STAGES; s++) begin
        pipe_q[s] <= pipe_q[s-1];
      end
      prev_q <= pipe_q[LAST][EDGE_LANES-1:0];
    end
  end

  assign lvl_o  = pipe_q[LAST];
  assign fall_o = prev_q & ~pipe_q[LAST][EDGE_LANES-1:0];

  // A detected fall is a one-cycle event on each lane
  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0)) else $error("fall pulse held"); // R4

endmodule

// File: rtl/shade_ramp_fsm.sv
`timescale 1ns/1ps
module shade_ramp_fsm
  import scan_shade_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] floor_i,
  input  logic [CNT_W-1:0] dump_len_i,
  output logic             busy_o
);

  localparam int unsigned XW = CNT_W + 1;

  function automatic logic reached_top(input logic [CNT_W-1:0] r, input logic [CNT_W-1:0] t);
    return r >= t;
  endfunction

  function automatic logic below_floor(input logic [CNT_W-1:0] r, input logic [CNT_W-1:0] f);
    return r < f;
  endfunction

  function automatic logic dump_over(input logic [CNT_W-1:0] tick, input logic [CNT_W-1:0] len);
    logic [XW-1:0] nxt;
    nxt = {1'b0, tick} + XW'(1);
    return nxt >= {1'b0, len};
  endfunction

  function automatic logic [CNT_W-1:0] decay(input logic [CNT_W-1:0] r);
    return r >> 1;
  endfunction

  shade_phase_e     phase_q;
  logic [CNT_W-1:0] ramp_q;
  logic [CNT_W-1:0] tick_q;

  // Named events for the assertions
  logic armed_w, start_evt, top_evt, dump_evt;

  assign armed_w   = (phase_q == PH_IDLE) && below_floor(ramp_q, floor_i);
  assign start_evt = run_i && trig_i && armed_w;
  assign top_evt   = run_i && (phase_q == PH_RISE) && reached_top(ramp_q, top_i);
  assign dump_evt  = run_i && (phase_q == PH_DUMP) && dump_over(tick_q, dump_len_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ramp_q  <= '0;
      tick_q  <= '0;
    end else if (!run_i) begin
      phase_q <= PH_IDLE;
      ramp_q  <= '0;
      tick_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start_evt) begin
            phase_q <= PH_RISE;
            ramp_q  <= ramp_q + 1'b1;
          end else begin
            ramp_q  <= decay(ramp_q);
          end
        end
        PH_RISE: begin
          if (top_evt) begin
            phase_q <= PH_DUMP;
            tick_q  <= '0;
          end else begin
            ramp_q  <= ramp_q + 1'b1;
          end
        end
        PH_DUMP: begin
          ramp_q <= decay(ramp_q);
          if (dump_evt) phase_q <= PH_IDLE;
          else          tick_q  <= tick_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o = run_i && (phase_q == PH_RISE);

  AST_START_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RISE && $past(phase_q) == PH_IDLE) |-> ($past(ramp_q) < $past(floor_i))) else $error("start unarmed"); // R4
  AST_RISE_CLIMBS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RISE && $past(phase_q) == PH_RISE) |-> (ramp_q == $past(ramp_q) + 1'b1)) else $error("ramp step"); // R7
  AST_NO_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && phase_q == PH_RISE) |=> (phase_q != PH_IDLE)) else $error("skipped discharge"); // R8
  AST_DUMP_NOT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DUMP) |=> (phase_q != PH_RISE)) else $error("retrigger in discharge"); // R8
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i) |=> (phase_q == PH_IDLE && ramp_q == '0)) else $error("disable kept state"); // R9

endmodule

// File: rtl/scan_out_cell.sv
`timescale 1ns/1ps
module scan_out_cell #(
  parameter bit SHADEABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic shade_i,
  input  logic lvl_i,
  output logic hi_o,
  output logic lo_o,
  output logic hiz_o,
  output logic dis_o
);

  logic float_w;

  generate
    if (SHADEABLE) begin : g_shade
      assign float_w = shade_i && !lvl_i;
    end else begin : g_plain
      logic unused_shade;
      assign unused_shade = shade_i;
      assign float_w = 1'b0;
    end
  endgenerate

  always_comb begin
    hi_o  = 1'b0;
    lo_o  = 1'b0;
    hiz_o = 1'b0;
    dis_o = 1'b0;
    if (!en_i) begin
      hiz_o = 1'b1;
    end else if (float_w) begin
      hiz_o = 1'b1;
      dis_o = 1'b1;
    end else begin
      hi_o = lvl_i;
      lo_o = !lvl_i;
    end
  end

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hi_o, lo_o, hiz_o}) == 1) else $error("drive state"); // R2
  AST_DIS_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_o |-> (hiz_o && en_i && shade_i)) else $error("discharge while driving"); // R5

endmodule

// File: rtl/scan_shade_ctrl.sv
`timescale 1ns/1ps
module scan_shade_ctrl
  import scan_shade_pkg::*;
#(
  parameter int unsigned NUM_CK      = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              shade_en,
  input  logic              st_in,
  input  logic [NUM_CK-1:0] ck_in,
  input  logic [CNT_W-1:0]  ramp_top,
  input  logic [CNT_W-1:0]  ramp_floor,
  input  logic [CNT_W-1:0]  dump_len,
  output logic              st_hi,
  output logic              st_lo,
  output logic              st_hiz,
  output logic [NUM_CK-1:0] ck_hi,
  output logic [NUM_CK-1:0] ck_lo,
  output logic [NUM_CK-1:0] ck_hiz,
  output logic [NUM_CK-1:0] ck_dis,
  output logic              rail_odd_on,
  output logic              rail_even_on,
  output logic              shade_busy
);

  localparam int unsigned LANES   = NUM_CK + 1;
  localparam int unsigned ST_LANE = NUM_CK;

  logic [LANES-1:0]  lvl_w;
  logic [NUM_CK-1:0] fall_w;
  logic              run_w;
  logic              trig_w;
  logic              busy_w;
  logic              st_dis_w;

  assign run_w  = chip_en && shade_en;
  assign trig_w = |fall_w;

  scan_edge_sync #(
    .LANES(LANES), .EDGE_LANES(NUM_CK), .STAGES(SYNC_STAGES)
  ) sync_i (
    .clk(clk), .rst_n(rst_n), .raw_i({st_in, ck_in}),
    .lvl_o(lvl_w), .fall_o(fall_w)
  );

  shade_ramp_fsm #(.CNT_W(CNT_W)) ramp_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .trig_i(trig_w),
    .top_i(ramp_top), .floor_i(ramp_floor), .dump_len_i(dump_len),
    .busy_o(busy_w)
  );

  generate
    for (genvar i = 0; i < NUM_CK; i++) begin : g_ck
      scan_out_cell #(.SHADEABLE(1'b1)) cell_i (
        .clk(clk), .rst_n(rst_n), .en_i(chip_en), .shade_i(busy_w),
        .lvl_i(lvl_w[i]), .hi_o(ck_hi[i]), .lo_o(ck_lo[i]),
        .hiz_o(ck_hiz[i]), .dis_o(ck_dis[i])
      );
    end
  endgenerate

  scan_out_cell #(.SHADEABLE(1'b0)) st_cell_i (
    .clk(clk), .rst_n(rst_n), .en_i(chip_en), .shade_i(busy_w),
    .lvl_i(lvl_w[ST_LANE]), .hi_o(st_hi), .lo_o(st_lo),
    .hiz_o(st_hiz), .dis_o(st_dis_w)
  );

  always_comb begin
    rail_odd_on  = 1'b0;
    rail_even_on = 1'b0;
    for (int unsigned i = 0; i < NUM_CK; i++) begin
      if (odd_rail_lane(i)) rail_odd_on  = rail_odd_on  | ck_dis[i];
      else                  rail_even_on = rail_even_on | ck_dis[i];
    end
  end

  assign shade_busy = busy_w;

  AST_OFF_ALL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (st_hiz && (&ck_hiz) && !rail_odd_on && !rail_even_on && !shade_busy)) else $error("not floating"); // R1
  AST_RAIL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_odd_on || rail_even_on) |-> shade_busy) else $error("rail outside window"); // R5
  AST_IDLE_NO_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    !shade_busy |-> (ck_dis == '0)) else $error("discharge while idle"); // R9
  AST_ST_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    chip_en |-> (!st_hiz && !st_dis_w)) else $error("start lane shaded"); // R10

endmodule

// File: tb/scan_shade_ctrl_tb.sv
`timescale 1ns/1ps
module scan_shade_ctrl_tb_top;

  localparam int NCK = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0, shade_en = 1'b0, st_in = 1'b0;
  logic [NCK-1:0] ck_in = '0;
  logic [15:0] ramp_top = 16'd5, ramp_floor = 16'd3, dump_len = 16'd4;
  logic st_hi, st_lo, st_hiz, rail_odd_on, rail_even_on, shade_busy;
  logic [NCK-1:0] ck_hi, ck_lo, ck_hiz, ck_dis;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scan_shade_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .shade_en(shade_en),
    .st_in(st_in), .ck_in(ck_in), .ramp_top(ramp_top), .ramp_floor(ramp_floor),
    .dump_len(dump_len), .st_hi(st_hi), .st_lo(st_lo), .st_hiz(st_hiz),
    .ck_hi(ck_hi), .ck_lo(ck_lo), .ck_hiz(ck_hiz), .ck_dis(ck_dis),
    .rail_odd_on(rail_odd_on), .rail_even_on(rail_even_on), .shade_busy(shade_busy)
  );

  // Requirement model: two-edge capture, countdowns for window and discharge,
  // ramp value tracked only at window open and through the halving decay.
  logic [NCK:0] m_c1, m_c2, m_old;
  int m_win, m_dump, m_ramp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c1 <= '0; m_c2 <= '0; m_old <= '0;
      m_win <= 0; m_dump <= 0; m_ramp <= 0;
    end else begin
      m_c1 <= {st_in, ck_in};
      m_c2 <= m_c1;
      m_old <= m_c2;
      if (!(chip_en && shade_en)) begin
        m_win <= 0; m_dump <= 0; m_ramp <= 0;
      end else if (m_win > 0) begin
        m_win <= m_win - 1;
        if (m_win == 1) begin
          m_dump <= (dump_len == 0) ? 1 : int'(dump_len);
          m_ramp <= (int'(ramp_top) > m_ramp) ? int'(ramp_top) : m_ramp + 1;
        end
      end else begin
        if (m_dump > 0) m_dump <= m_dump - 1;
        if (m_dump == 0 && ((m_old[NCK-1:0] & ~m_c2[NCK-1:0]) != '0) && m_ramp < int'(ramp_floor))
          m_win <= (int'(ramp_top) > m_ramp) ? int'(ramp_top) - m_ramp : 1;
        else
          m_ramp <= m_ramp / 2;
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit busy_e;
    bit [NCK-1:0] hi_e, lo_e, hiz_e, dis_e;
    bit odd_e, even_e;
    string tg;
    busy_e = chip_en && shade_en && (m_win > 0);
    odd_e = 0; even_e = 0;
    for (int i = 0; i < NCK; i++) begin
      hi_e[i] = 0; lo_e[i] = 0; hiz_e[i] = 0; dis_e[i] = 0;
      if (!chip_en) hiz_e[i] = 1;
      else if (busy_e && !m_c2[i]) begin hiz_e[i] = 1; dis_e[i] = 1; end
      else begin hi_e[i] = m_c2[i]; lo_e[i] = !m_c2[i]; end
      if (i % 2 == 0) odd_e |= dis_e[i]; else even_e |= dis_e[i];
    end
    tg = !chip_en ? "R1" : (busy_e ? "R5" : "R2");
    chk(tg, "ck_hi", ck_hi, hi_e);
    chk(tg, "ck_lo", ck_lo, lo_e);
    chk(tg, "ck_hiz", ck_hiz, hiz_e);
    chk(tg, "ck_dis", ck_dis, dis_e);
    chk("R6", "rails", {rail_odd_on, rail_even_on}, {odd_e, even_e});
    chk("R7", "shade_busy", shade_busy, busy_e);
    tg = chip_en ? "R10" : "R1";
    chk(tg, "st_drive", {st_hi, st_lo, st_hiz},
        chip_en ? {m_c2[NCK], !m_c2[NCK], 1'b0} : 3'b001);
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd20240607));
    chip_en = 1'b1;
    step(3);
    chk("R1", "reset st_lo", st_lo, 1);
    chk("R1", "reset busy", shade_busy, 0);
    rst_n = 1'b1;
    shade_en = 1'b1;
    step(2);
    // R2 latency: change seen after two edges
    ck_in = '1; st_in = 1'b1;
    step(1);
    chk("R2", "one edge still low", ck_lo, 6'h3F);
    step(1);
    chk("R2", "two edges high", ck_hi, 6'h3F);
    step(6);
    // R3 glitch between edges
    @(posedge clk); #0.5 ck_in[1] = 1'b0; #1 ck_in[1] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step(1);
      chk("R3", "glitch busy", shade_busy, 0);
      chk("R3", "glitch lane", ck_hi[1], 1);
    end
    // R4 start latency
    ck_in[2] = 1'b0;
    step(2);
    chk("R4", "busy before third edge", shade_busy, 0);
    step(1);
    chk("R4", "busy after third edge", shade_busy, 1);
    chk("R5", "low lane floats+dis", {ck_hiz[2], ck_dis[2]}, 2'b11);
    chk("R5", "high lane drives", ck_hi[1], 1);
    chk("R6", "lane 2 odd rail", {rail_odd_on, rail_even_on}, 2'b10);
    cnt = 1;
    while (shade_busy && cnt < 100) begin
      step(1);
      if (shade_busy) cnt++;
    end
    chk("R7", "window length", cnt, 5);
    // R8 edge in discharge ignored
    ck_in[4] = 1'b0;
    for (int k = 0; k < 8; k++) begin
      step(1);
      chk("R8", "no retrigger in discharge", shade_busy, 0);
    end
    ck_in = '1;
    step(12);
    // R6 even rail and R10 start lane during window
    ck_in[1] = 1'b0;
    step(3);
    chk("R6", "lane 1 even rail", {rail_odd_on, rail_even_on}, 2'b01);
    chk("R8", "re-armed after decay", shade_busy, 1);
    st_in = 1'b0;
    step(2);
    chk("R10", "start lane follows in window", {st_lo, st_hiz}, 2'b10);
    ck_in = '1; st_in = 1'b1;
    step(15);
    // R9 shading disabled
    shade_en = 1'b0;
    step(2);
    ck_in[0] = 1'b0;
    step(3);
    chk("R9", "no window when disabled", shade_busy, 0);
    chk("R9", "lane follows", ck_lo[0], 1);
    ck_in[0] = 1'b1; shade_en = 1'b1;
    step(10);
    // R11 zero floor
    ramp_floor = 16'd0;
    ck_in[5] = 1'b0;
    step(4);
    chk("R11", "zero floor never arms", shade_busy, 0);
    ck_in[5] = 1'b1; ramp_floor = 16'd3;
    step(5);
    // R1 chip disable
    chip_en = 1'b0;
    step(1);
    chk("R1", "all float", {st_hiz, ck_hiz}, 7'h7F);
    chk("R1", "rails off", {rail_odd_on, rail_even_on}, 0);
    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      chip_en = 1'b0;
      step(3);
      ramp_top   = 16'(2 + $urandom % 18);
      ramp_floor = 16'($urandom % 6);
      dump_len   = 16'($urandom % 9);
      shade_en   = (ph != 5);
      chip_en    = 1'b1;
      repeat (1500) begin
        step(1);
        for (int b = 0; b < NCK; b++) if ($urandom % 8 == 0) ck_in[b] = ~ck_in[b];
        if ($urandom % 16 == 0) st_in = ~st_in;
        if ($urandom % 500 == 0) shade_en = ~shade_en;
        if ($urandom % 700 == 0) chip_en = ~chip_en;
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule